// File: doc/BRIEF.md
# Packet Stream Buffer with Split Metadata Store

This block buffers a packet stream that moves under a valid/ready handshake. Every beat carries a payload word, an end-of-packet flag and a 112-bit metadata record. The record is constant for the whole packet. For UDP traffic it holds the length, the two port numbers and the two IPv4 addresses.

Payload words and their end flags go into a deep queue. The metadata record goes into a separate, much shallower queue, and only once per packet. It is written when the packet's first beat is accepted. At the output the two queues are joined again, so every beat leaves with the metadata of its own packet. The head record is released when that packet's final beat leaves.

The block sits between a packet producer and a consumer on one clock. It absorbs backpressure without spending storage on a copy of the record for every word.

Top module: `meta_split_stream_buf`

## Requirements
- R1: A beat moves at the input only in a cycle where in_valid and in_ready are both 1, and at the output only where out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, out_valid, out_data, out_last and out_meta hold their values into the next cycle.
- R2: After reset, in_ready is 1 and out_valid is 0.
- R3: The payload queue holds PAY_DEPTH beats. With the output stalled, exactly PAY_DEPTH beats are accepted, and in_ready is then 0.
- R4: The metadata queue holds META_DEPTH packets. When it is full, in_ready is 0 while the next beat would start a new packet. Beats that continue a packet already started are still accepted.
- R5: in_meta is sampled only on the first beat of a packet. A packet starts on the first beat after reset, and on the first beat after a beat accepted with in_last = 1. Any in_meta value on later beats of the packet has no effect on out_meta.
- R6: out_valid is 1 only when a payload beat and its metadata are both stored. A beat accepted into an empty buffer raises out_valid in the following cycle, not in the cycle of acceptance.
- R7: Beats leave in the order they arrived, with the same data and last flag.
- R8: Every output beat shows the metadata of its own packet. After a beat with out_last = 1 is taken, the next packet's metadata is shown.
- R9: A packet of a single beat (in_last = 1 on its first beat) stores and releases exactly one metadata record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Buffer can take the offered beat |
| in_data | input | DATA_W | Input payload word |
| in_last | input | 1 | Input beat ends its packet |
| in_meta | input | 112 | Packet metadata, sampled on the first beat of a packet |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Consumer takes the offered beat |
| out_data | output | DATA_W | Output payload word |
| out_last | output | 1 | Output beat ends its packet |
| out_meta | output | 112 | Metadata of the packet the output beat belongs to |

## Verification
The bench builds the block with DATA_W = 16, PAY_DEPTH = 16 and META_DEPTH = 4. With these small depths, both the payload-full limit and the metadata-full limit are reached within a few tens of cycles. Some of the table-driven packets are longer than the whole payload queue, and some runs use only single-beat packets. Under random backpressure these exercise both stall paths, including the case where a started packet continues while the metadata queue is full.

// File: rtl/meta_buf_pkg.sv
package meta_buf_pkg;

  localparam int META_W = 112;

  typedef struct packed {
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [15:0] src_port;
    logic [15:0] dst_port;
    logic [15:0] length;
  } flow_meta_t;

  // index step with wrap for a ring of any depth
  function automatic int ring_next(input int cur, input int depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction

  // occupancy after one cycle of push/pop
  function automatic int fill_next(input int fill, input bit push, input bit pop);
    return fill + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/buf_fifo.sv
module buf_fifo
  import meta_buf_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      fill <= CW'(fill_next(int'(fill), do_push, do_pop));
    end
  end
endmodule

// File: rtl/admit_ctl.sv
module admit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic pay_full,
  input  logic meta_full,
  output logic in_ready,
  output logic pay_push,
  output logic meta_push,
  output logic at_sop
);
  logic in_fire;

  // a new packet needs room in both queues; a continuation needs only payload room
  assign in_ready  = !pay_full && !(at_sop && meta_full);
  assign in_fire   = in_valid && in_ready;
  assign pay_push  = in_fire;
  assign meta_push = in_fire && at_sop;

  always_ff @(posedge clk) begin
    if (!rst_n)       at_sop <= 1'b1;
    else if (in_fire) at_sop <= in_last;
  end
endmodule

// File: rtl/egress_join.sv
module egress_join (
  input  logic out_ready,
  input  logic pay_empty,
  input  logic meta_empty,
  input  logic pay_last,
  output logic out_valid,
  output logic pay_pop,
  output logic meta_pop
);
  assign out_valid = !pay_empty && !meta_empty;
  assign pay_pop   = out_valid && out_ready;
  assign meta_pop  = pay_pop && pay_last;
endmodule

// File: rtl/meta_split_stream_buf.sv
module meta_split_stream_buf
  import meta_buf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAY_DEPTH  = 512,
  parameter int META_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [META_W-1:0] in_meta,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic [META_W-1:0] out_meta
);
  localparam int PW = DATA_W + 1;

  logic pay_push, pay_pop, pay_full, pay_empty;
  logic meta_push, meta_pop, meta_full, meta_empty;
  logic at_sop;
  logic [PW-1:0] pay_rdata;

  admit_ctl u_admit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .pay_full(pay_full), .meta_full(meta_full), .in_ready(in_ready),
    .pay_push(pay_push), .meta_push(meta_push), .at_sop(at_sop)
  );

  buf_fifo #(.W(PW), .DEPTH(PAY_DEPTH)) u_pay (
    .clk(clk), .rst_n(rst_n), .push(pay_push), .wdata({in_last, in_data}),
    .pop(pay_pop), .rdata(pay_rdata), .full(pay_full), .empty(pay_empty)
  );

  buf_fifo #(.W(META_W), .DEPTH(META_DEPTH)) u_meta (
    .clk(clk), .rst_n(rst_n), .push(meta_push), .wdata(in_meta),
    .pop(meta_pop), .rdata(out_meta), .full(meta_full), .empty(meta_empty)
  );

  assign out_data = pay_rdata[DATA_W-1:0];
  assign out_last = pay_rdata[DATA_W];

  egress_join u_egress (
    .out_ready(out_ready), .pay_empty(pay_empty), .meta_empty(meta_empty),
    .pay_last(out_last), .out_valid(out_valid), .pay_pop(pay_pop),
    .meta_pop(meta_pop)
  );
endmodule

// File: rtl/meta_split_stream_buf_chk.sv
module meta_split_stream_buf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic [111:0]      out_meta,
  input logic              pay_full,
  input logic              pay_empty,
  input logic              meta_full,
  input logic              meta_empty,
  input logic              at_sop
);
  logic         mid_pkt;
  logic [111:0] held_meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_pkt   <= 1'b0;
      held_meta <= '0;
    end else if (out_valid && out_ready) begin
      mid_pkt   <= !out_last;
      held_meta <= out_meta;
    end
  end

  p_hold_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_meta)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pay_full |-> !in_ready);

  p_meta_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sop && meta_full) |-> !in_ready);

  p_meta_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pay_empty |-> !meta_empty);

  p_meta_const_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mid_pkt) |-> (out_meta == held_meta));
endmodule

bind meta_split_stream_buf meta_split_stream_buf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .out_meta(out_meta), .pay_full(pay_full), .pay_empty(pay_empty),
  .meta_full(meta_full), .meta_empty(meta_empty), .at_sop(at_sop)
);

// File: tb/test_meta_split_stream_buf.sv
module test_meta_split_stream_buf;
  import meta_buf_pkg::*;

  localparam int DW = 16;
  localparam int PD = 16;
  localparam int MD = 4;
  localparam int NROWS = 6;
  // {packets, max length, input valid %, output ready %}
  localparam logic [31:0] PLAN [NROWS] = '{
    {8'd6,  8'd5,  8'd100, 8'd100},
    {8'd10, 8'd9,  8'd60,  8'd40},
    {8'd20, 8'd1,  8'd70,  8'd50},
    {8'd6,  8'd24, 8'd90,  8'd25},
    {8'd12, 8'd3,  8'd30,  8'd90},
    {8'd15, 8'd6,  8'd50,  8'd50}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic [111:0] in_meta = '0;
  logic in_ready, out_valid, out_last;
  logic [DW-1:0] out_data;
  logic [111:0] out_meta;

  always #4 clk = ~clk;

  meta_split_stream_buf #(.DATA_W(DW), .PAY_DEPTH(PD), .META_DEPTH(MD)) i_meta_split_stream_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_meta(in_meta),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_meta(out_meta)
  );

  int n_checks = 0, n_fail = 0;
  logic [128:0] exp_q [$];
  logic [111:0] cur_meta;
  bit bench_sop = 1;
  bit in_fire_g, out_fire_g;
  int in_beats = 0, out_beats = 0;
  logic [DW-1:0] seq = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [111:0] mk_meta(input int p, input int len);
    flow_meta_t f;
    f.src_ip   = 32'hC0A8_0000 + 32'(p);
    f.dst_ip   = 32'h0A00_0000 ^ 32'(p * 977);
    f.src_port = 16'(1024 + p);
    f.dst_port = 16'(p * 3 + 7);
    f.length   = 16'(len);
    return f;
  endfunction

  function automatic int plen(input int p, input int maxlen);
    return 1 + ((p * 7 + 3) % maxlen);
  endfunction

  // one clock: drive 2 ns after the edge, evaluate handshakes 5 ns after
  task automatic step(input bit v, input logic [DW-1:0] d, input bit l,
                      input logic [111:0] m, input bit r);
    logic [128:0] e;
    @(posedge clk);
    #2;
    in_valid = v; in_data = d; in_last = l; in_meta = m; out_ready = r;
    #3;
    in_fire_g  = in_valid && in_ready;
    out_fire_g = out_valid && out_ready;
    if (out_fire_g) begin
      out_beats++;
      if (exp_q.size() == 0) begin
        check(0, "R7", "unexpected output beat", 160'(out_data), 160'(0));
      end else begin
        e = exp_q.pop_front();
        check({out_meta, out_last, out_data} == e, "R5 R7 R8",
              "output beat {meta,last,data}",
              160'({out_meta, out_last, out_data}), 160'(e));
      end
    end
    if (in_fire_g) begin
      in_beats++;
      if (bench_sop) cur_meta = in_meta;
      exp_q.push_back({cur_meta, in_last, in_data});
      bench_sop = in_last;
    end
  endtask

  task automatic idle(input bit r);
    step(0, '0, 0, '0, r);
  endtask

  task automatic drain();
    int g = 0;
    while (exp_q.size() != 0 && g < 1000) begin idle(1); g++; end
    check(exp_q.size() == 0, "R7", "drain empties buffer", 160'(exp_q.size()), 160'(0));
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int pk = 0;
    repeat (3) @(posedge clk);
    #5;
    check(in_ready == 1, "R2", "in_ready in reset", 160'(in_ready), 160'(1));
    check(out_valid == 0, "R2", "out_valid in reset", 160'(out_valid), 160'(0));
    @(posedge clk); #2; rst_n = 1;
    #3;
    check(in_ready == 1 && out_valid == 0, "R2", "{in_ready,out_valid} after reset",
          160'({in_ready, out_valid}), 160'(2'b10));

    // table-driven random traffic (single-beat row covers R9)
    for (int row = 0; row < NROWS; row++) begin
      int np, ml, ip, op, sent, beat, len, guard, b0;
      np = int'(PLAN[row][31:24]); ml = int'(PLAN[row][23:16]);
      ip = int'(PLAN[row][15:8]);  op = int'(PLAN[row][7:0]);
      sent = 0; beat = 0; guard = 0; len = plen(pk, ml);
      b0 = in_beats;
      while ((sent < np || exp_q.size() != 0) && guard < 20000) begin
        bit v, r;
        v = (sent < np) && (($urandom % 100) < ip);
        r = ($urandom % 100) < op;
        step(v, seq, beat == len - 1,
             (beat == 0) ? mk_meta(pk, len) : ~mk_meta(pk, len), r);
        if (in_fire_g) begin
          seq++;
          if (beat == len - 1) begin
            beat = 0; sent++; pk++; len = plen(pk, ml);
          end else beat++;
        end
        guard++;
      end
      check(exp_q.size() == 0 && out_beats == in_beats, "R7 R9",
            "row completes, beats in == beats out",
            160'(out_beats), 160'(in_beats));
      if (ml == 1)
        check(in_beats - b0 == np, "R9", "single-beat row beat count",
              160'(in_beats - b0), 160'(np));
    end

    // R6: one beat into empty buffer
    step(1, 16'hA5A5, 1, mk_meta(900, 1), 0);
    check(in_fire_g && out_valid == 0, "R6", "out_valid in accept cycle",
          160'(out_valid), 160'(0));
    idle(0);
    check(out_valid == 1 && out_meta == mk_meta(900, 1), "R6",
          "out_valid/meta one cycle later", 160'(out_meta), 160'(mk_meta(900, 1)));
    drain();
    idle(0);
    check(out_valid == 0, "R6", "out_valid after drain", 160'(out_valid), 160'(0));

    // R4: metadata queue full blocks new packet only
    for (int i = 0; i < MD; i++) step(1, 16'(i), 1, mk_meta(910 + i, 1), 0);
    idle(0);
    check(in_ready == 0, "R4", "in_ready with meta queue full at packet start",
          160'(in_ready), 160'(0));
    drain();
    for (int i = 0; i < MD - 1; i++) step(1, 16'(i), 1, mk_meta(920 + i, 1), 0);
    step(1, 16'h0100, 0, mk_meta(930, 3), 0);
    check(in_fire_g == 1, "R4", "last packet start accepted", 160'(in_fire_g), 160'(1));
    step(1, 16'h0101, 0, ~mk_meta(930, 3), 0);
    check(in_fire_g == 1, "R4", "continuation accepted with meta full",
          160'(in_fire_g), 160'(1));
    step(1, 16'h0102, 1, ~mk_meta(930, 3), 0);
    check(in_fire_g == 1, "R4", "final beat accepted with meta full",
          160'(in_fire_g), 160'(1));
    idle(0);
    check(in_ready == 0, "R4", "in_ready after packet end, meta full",
          160'(in_ready), 160'(0));
    drain();

    // R3 and R1: payload capacity and output hold under stall
    begin
      int acc = 0;
      for (int i = 0; i < PD + 3; i++) begin
        step(1, 16'(16'h0200 + i), 0, (i == 0) ? mk_meta(940, PD) : ~mk_meta(940, PD), 0);
        if (in_fire_g) acc++;
      end
      check(acc == PD, "R3", "beats accepted while stalled", 160'(acc), 160'(PD));
      check(in_ready == 0, "R3", "in_ready with payload full", 160'(in_ready), 160'(0));
      check(out_valid == 1 && out_data == 16'h0200 && out_meta == mk_meta(940, PD),
            "R1", "head beat held across stall", 160'(out_data), 160'(16'h0200));
      acc = 0;
      while (acc < 200) begin
        step(1, 16'h02FF, 1, ~mk_meta(940, PD), 1);
        acc++;
        if (in_fire_g) break;
      end
      drain();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule